// File: doc/BRIEF.md
# Three-Level Overcurrent Delay Detector

This block turns three discharge-current comparator flags into one latched overcurrent trip. The lowest level has an adjustable threshold. The two higher levels correspond to fixed thresholds of 0.5 V and 1.2 V across the sense pin. Each level has its own qualification delay, and the block counts that delay in ticks of a slow oscillator.

All three delays are measured by one shared counter. The counter starts when the lowest level is first seen. As a result, a higher level is timed from that first crossing and not from the moment its own comparator fired.

When a level qualifies, the trip output latches. Outside the block, this output turns off both the charge and discharge switches and asks for the sense pin to be pulled up to the supply. The trip stays set until the lowest-level flag goes away, which happens when a charger is attached or the load is removed. A second output reports which level caused the trip.

An enable input switches off lowest-level detection, which is what a test-mode control setting requires. A delay-shortening input divides the two longer delays so that they can be checked quickly.

Top module: `oc_trip_detector`

## Requirements
- R1: After a synchronous reset, `trip` is 0 and `trip_src` is 0.
- R2: With `oc_lvl1` and `lvl1_en` held high, `trip` rises with `trip_src` = 1 in the cycle after the L1_TICKS-th `tick`, and not before.
- R3: When `oc_lvl2` is high on the tick at which the shared count reaches L2_TICKS, the block trips with `trip_src` = 2.
- R4: When `oc_lvl3` is high on a counted tick at which the count is L3_TICKS or more, the block trips with `trip_src` = 3. With the default of 1, this happens on the first tick.
- R5: The higher-level delays are counted from the first `oc_lvl1` detection. If `oc_lvl2` rises after the count has already passed L2_TICKS, the block trips on the next tick on which `oc_lvl2` is high.
- R6: `trip_src` encodes 0 for no trip and 1, 2 or 3 for the tripping level. When several levels qualify on the same tick, the highest level is reported.
- R7: If `oc_lvl1` drops before a trip, the shared count is cleared, so a new detection needs the full delay again.
- R8: Once `trip` is set, it holds with an unchanged `trip_src` while `oc_lvl1` stays high, whatever `oc_lvl2` and `oc_lvl3` do. In the cycle after `oc_lvl1` is seen low, `trip` and `trip_src` return to 0.
- R9: While `lvl1_en` is low, nothing is counted and no trip happens at any flag level, and the count is cleared.
- R10: With `fast_mode` high, the level-1 and level-2 delays become L1_TICKS/32 and L2_TICKS/32 ticks, each with a minimum of 1. The level-3 delay is unchanged.
- R11: The count advances only on cycles with `tick` high. Without ticks, no trip occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle oscillator tick that paces the delays |
| oc_lvl1 | input | 1 | Lowest-level (adjustable) overcurrent comparator flag |
| oc_lvl2 | input | 1 | Middle-level overcurrent comparator flag |
| oc_lvl3 | input | 1 | Highest-level (short-circuit) comparator flag |
| lvl1_en | input | 1 | Lowest-level detection enable; low disables all detection |
| fast_mode | input | 1 | Delay-shortening mode |
| trip | output | 1 | Latched overcurrent trip; drives both switch disables and the sense pull-up request |
| trip_src | output | 2 | Tripping level: 0 none, 1, 2 or 3 |

## Verification
The block is tried with several input patterns:
- Each level alone, held from the first crossing. These runs tell the three delays apart.
- A late rise of the middle flag. This shows that the delay is counted from the shared start and not from the middle flag's own rise.
- Simultaneous rises of the two upper flags. These expose the priority order.
- A short gap in the lowest flag before a trip. This separates a cleared count from one that is only held.
- The enable and fast-mode inputs, and long stretches without ticks. These check that counting depends on enable, on the shortened limits and on the tick alone.

// File: rtl/oc_trip_pkg.sv
package oc_trip_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_L1   = 2'd1,
    SRC_L2   = 2'd2,
    SRC_L3   = 2'd3
  } trip_src_e;

  localparam int NUM_LEVELS = 3;

  function automatic int shrink_limit(input int full, input int div);
    int r;
    r = full / div;
    if (r < 1) r = 1;
    return r;
  endfunction
endpackage

// File: rtl/oc_delay_limits.sv
module oc_delay_limits #(
  parameter int L1_TICKS = 32,
  parameter int L2_TICKS = 16,
  parameter int L3_TICKS = 1,
  parameter int SHRINK   = 32,
  parameter int CW       = 6
) (
  input  logic                                      fast_mode,
  output logic [oc_trip_pkg::NUM_LEVELS-1:0][CW-1:0] lim
);
  import oc_trip_pkg::*;

  localparam int FULL1 = (L1_TICKS < 1) ? 1 : L1_TICKS;
  localparam int FULL2 = (L2_TICKS < 1) ? 1 : L2_TICKS;
  localparam int FULL3 = (L3_TICKS < 1) ? 1 : L3_TICKS;
  localparam int FAST1 = shrink_limit(FULL1, SHRINK);
  localparam int FAST2 = shrink_limit(FULL2, SHRINK);

  always_comb begin
    lim[0] = fast_mode ? CW'(FAST1) : CW'(FULL1);
    lim[1] = fast_mode ? CW'(FAST2) : CW'(FULL2);
    lim[2] = CW'(FULL3);
  end
endmodule

// File: rtl/oc_shared_counter.sv
module oc_shared_counter #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  output logic [CW-1:0] count_inc
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [CW-1:0] count;

  assign count_inc = (count == CNT_MAX) ? count : count + CW'(1);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count <= '0;
    end else if (step) begin
      count <= count_inc;
    end
  end
endmodule

// File: rtl/oc_level_qualify.sv
module oc_level_qualify #(
  parameter int CW = 6
) (
  input  logic                                      step,
  input  logic [CW-1:0]                             count_inc,
  input  logic [oc_trip_pkg::NUM_LEVELS-1:0]        flags,
  input  logic [oc_trip_pkg::NUM_LEVELS-1:0][CW-1:0] lim,
  output logic                                      hit,
  output oc_trip_pkg::trip_src_e                    src
);
  import oc_trip_pkg::*;

  logic [NUM_LEVELS-1:0] qual;

  for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_qual
    assign qual[k] = step && flags[k] && (count_inc >= lim[k]);
  end

  always_comb begin
    hit = |qual;
    if (qual[2])      src = SRC_L3;
    else if (qual[1]) src = SRC_L2;
    else if (qual[0]) src = SRC_L1;
    else              src = SRC_NONE;
  end
endmodule

// File: rtl/oc_trip_detector.sv
module oc_trip_detector #(
  parameter int L1_TICKS = 32,
  parameter int L2_TICKS = 16,
  parameter int L3_TICKS = 1,
  parameter int SHRINK   = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       oc_lvl1,
  input  logic       oc_lvl2,
  input  logic       oc_lvl3,
  input  logic       lvl1_en,
  input  logic       fast_mode,
  output logic       trip,
  output logic [1:0] trip_src
);
  import oc_trip_pkg::*;

  localparam int MAXL = (L1_TICKS > L2_TICKS) ?
                        ((L1_TICKS > L3_TICKS) ? L1_TICKS : L3_TICKS) :
                        ((L2_TICKS > L3_TICKS) ? L2_TICKS : L3_TICKS);
  localparam int CW   = $clog2(MAXL + 2);

  logic [NUM_LEVELS-1:0][CW-1:0] lim;
  logic [CW-1:0]                 count_inc;
  logic                          detect;
  logic                          step;
  logic                          clear;
  logic                          hit;
  trip_src_e                     sel_src;
  trip_src_e                     src_q;
  logic                          trip_q;

  assign detect = oc_lvl1 && lvl1_en;
  assign step   = !trip_q && detect && tick;
  assign clear  = trip_q ? !oc_lvl1 : !detect;

  oc_delay_limits #(
    .L1_TICKS(L1_TICKS), .L2_TICKS(L2_TICKS), .L3_TICKS(L3_TICKS),
    .SHRINK(SHRINK), .CW(CW)
  ) u_limits (
    .fast_mode(fast_mode),
    .lim      (lim)
  );

  oc_shared_counter #(.CW(CW)) u_count (
    .clk      (clk),
    .rst      (rst),
    .clear    (clear),
    .step     (step),
    .count_inc(count_inc)
  );

  oc_level_qualify #(.CW(CW)) u_qual (
    .step     (step),
    .count_inc(count_inc),
    .flags    ({oc_lvl3, oc_lvl2, oc_lvl1}),
    .lim      (lim),
    .hit      (hit),
    .src      (sel_src)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trip_q <= 1'b0;
      src_q  <= SRC_NONE;
    end else if (trip_q) begin
      if (!oc_lvl1) begin
        trip_q <= 1'b0;
        src_q  <= SRC_NONE;
      end
    end else if (hit) begin
      trip_q <= 1'b1;
      src_q  <= sel_src;
    end
  end

  assign trip     = trip_q;
  assign trip_src = src_q;
endmodule

// File: rtl/oc_trip_detector_chk.sv
module oc_trip_detector_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       oc_lvl1,
  input logic       oc_lvl2,
  input logic       oc_lvl3,
  input logic       lvl1_en,
  input logic       fast_mode,
  input logic       trip,
  input logic [1:0] trip_src
);
  AST_IDLE_SRC_ZERO: assert property (@(posedge clk) disable iff (rst) !trip |-> trip_src == 2'd0); // R6
  AST_TRIP_SRC_VALID: assert property (@(posedge clk) disable iff (rst) trip |-> trip_src != 2'd0); // R6
  AST_TRIP_HOLDS: assert property (@(posedge clk) disable iff (rst) (trip && oc_lvl1) |=> (trip && $stable(trip_src))); // R8
  AST_TRIP_RELEASE: assert property (@(posedge clk) disable iff (rst) (trip && !oc_lvl1) |=> !trip); // R8
  AST_NO_TRIP_DISABLED: assert property (@(posedge clk) disable iff (rst) (!trip && !lvl1_en) |=> !trip); // R9
  AST_NO_TRIP_NO_TICK: assert property (@(posedge clk) disable iff (rst) (!trip && !tick) |=> !trip); // R11
  AST_NO_TRIP_NO_LVL1: assert property (@(posedge clk) disable iff (rst) (!trip && !oc_lvl1) |=> !trip); // R7
endmodule

bind oc_trip_detector oc_trip_detector_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick), .oc_lvl1(oc_lvl1), .oc_lvl2(oc_lvl2),
  .oc_lvl3(oc_lvl3), .lvl1_en(lvl1_en), .fast_mode(fast_mode),
  .trip(trip), .trip_src(trip_src)
);

// File: tb/oc_trip_detector_test.sv
module oc_trip_detector_test;
  localparam int L1 = 32;
  localparam int L2 = 16;
  localparam int L3 = 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0, oc1 = 1'b0, oc2 = 1'b0, oc3 = 1'b0;
  logic       en = 1'b1, fast = 1'b0;
  logic       trip;
  logic [1:0] trip_src;

  int    n_checks = 0;
  int    n_fails  = 0;
  string cur_req  = "R1";

  // reference model state
  int m_cnt  = 0;
  bit m_trip = 0;
  int m_src  = 0;

  always #2.5 clk = ~clk;

  oc_trip_detector #(.L1_TICKS(L1), .L2_TICKS(L2), .L3_TICKS(L3), .SHRINK(32)) uut (
    .clk(clk), .rst(rst), .tick(tick), .oc_lvl1(oc1), .oc_lvl2(oc2), .oc_lvl3(oc3),
    .lvl1_en(en), .fast_mode(fast), .trip(trip), .trip_src(trip_src)
  );

  function automatic int eff_limit(int full, bit f);
    int r;
    r = f ? full / 32 : full;
    return (r < 1) ? 1 : r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_trip = 0; m_src = 0;
    end else if (m_trip) begin
      if (!oc1) begin m_trip = 0; m_src = 0; m_cnt = 0; end
    end else if (oc1 && en) begin
      if (tick) begin
        m_cnt = m_cnt + 1;
        if (oc3 && m_cnt >= L3) begin m_trip = 1; m_src = 3; end
        else if (oc2 && m_cnt >= eff_limit(L2, fast)) begin m_trip = 1; m_src = 2; end
        else if (m_cnt >= eff_limit(L1, fast)) begin m_trip = 1; m_src = 1; end
      end
    end else begin
      m_cnt = 0;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      n_checks++;
      if (trip !== m_trip || trip_src !== 2'(m_src)) begin
        n_fails++;
        $display("FAIL %s model: trip=%0b src=%0d expected trip=%0b src=%0d",
                 cur_req, trip, trip_src, m_trip, m_src);
      end
    end
  end

  task automatic expect_out(string req, bit t, int s);
    n_checks++;
    if (trip !== t || trip_src !== 2'(s)) begin
      n_fails++;
      $display("FAIL %s: trip=%0b src=%0d expected trip=%0b src=%0d", req, trip, trip_src, t, s);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic release_all();
    @(negedge clk) begin oc1 = 0; oc2 = 0; oc3 = 0; end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_out("R1", 0, 0);

    cur_req = "R2";
    @(negedge clk) oc1 = 1;
    ticks(L1 - 1);
    expect_out("R2", 0, 0);
    ticks(1);
    expect_out("R2", 1, 1);

    cur_req = "R8";
    @(negedge clk) oc1 = 0;
    @(negedge clk);
    expect_out("R8", 0, 0);

    cur_req = "R3";
    @(negedge clk) begin oc1 = 1; oc2 = 1; end
    ticks(L2 - 1);
    expect_out("R3", 0, 0);
    ticks(1);
    expect_out("R3", 1, 2);
    release_all();

    cur_req = "R4";
    @(negedge clk) begin oc1 = 1; oc3 = 1; end
    ticks(1);
    expect_out("R4", 1, 3);
    release_all();

    cur_req = "R5";
    @(negedge clk) oc1 = 1;
    ticks(20);
    expect_out("R5", 0, 0);
    @(negedge clk) oc2 = 1;
    ticks(1);
    expect_out("R5", 1, 2);
    release_all();

    cur_req = "R6";
    @(negedge clk) oc1 = 1;
    ticks(20);
    @(negedge clk) begin oc2 = 1; oc3 = 1; end
    ticks(1);
    expect_out("R6", 1, 3);

    cur_req = "R8";
    @(negedge clk) begin oc2 = 0; oc3 = 0; end
    ticks(5);
    expect_out("R8", 1, 3);
    release_all();
    expect_out("R8", 0, 0);

    cur_req = "R7";
    @(negedge clk) oc1 = 1;
    ticks(20);
    @(negedge clk) oc1 = 0;
    @(negedge clk) oc1 = 1;
    ticks(L1 - 1);
    expect_out("R7", 0, 0);
    ticks(1);
    expect_out("R7", 1, 1);
    release_all();

    cur_req = "R9";
    @(negedge clk) begin en = 0; oc1 = 1; oc3 = 1; oc2 = 1; end
    ticks(L1 + 8);
    expect_out("R9", 0, 0);
    @(negedge clk) begin en = 1; oc2 = 0; oc3 = 0; end
    ticks(L1 - 1);
    expect_out("R9", 0, 0);
    ticks(1);
    expect_out("R9", 1, 1);
    release_all();

    cur_req = "R10";
    @(negedge clk) begin fast = 1; oc1 = 1; end
    ticks(1);
    expect_out("R10", 1, 1);
    release_all();
    @(negedge clk) begin oc1 = 1; oc2 = 1; end
    ticks(1);
    expect_out("R10", 1, 2);
    release_all();
    @(negedge clk) fast = 0;

    cur_req = "R11";
    @(negedge clk) begin oc1 = 1; oc3 = 1; end
    idle(200);
    expect_out("R11", 0, 0);
    ticks(1);
    expect_out("R11", 1, 3);
    release_all();

    cur_req = "R1";
    @(negedge clk) begin oc1 = 1; oc3 = 1; end
    ticks(1);
    @(negedge clk) rst = 1;
    @(negedge clk) begin rst = 0; oc1 = 0; oc3 = 0; end
    expect_out("R1", 0, 0);
    idle(2);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule